// File: doc/BRIEF.md
# Stereo Gain Ramp with Silence Detection

This block scales a stereo pair of signed audio samples by a 10-bit level for each channel. The level never jumps. Each channel keeps a requested level and an applied level. At every sample frame strobe the applied level moves by one code toward its target. The target is the request, or code zero while mute is active. A new request is loaded by a one-cycle load pulse. It becomes the target at the next frame strobe after the load.

Each channel also counts consecutive all-zero input samples. It raises a silence flag once the run exceeds a parameterised length. Any non-zero sample clears the count and the flag. A synchronous soft power-down returns all state to its reset values, the same as the asynchronous reset does.

Top module: `audio_vol_ramp`

## Requirements
- R1: After reset, both applied levels and both requested levels are all-ones (0x3FF for a 10-bit level). No request is pending, both outputs are 0 and both silence flags are 0.
- R2: At each frame strobe, a channel's applied level moves exactly one code toward its target. It stays unchanged when it already equals the target.
- R3: The applied levels and the outputs do not change in cycles without a frame strobe.
- R4: A level loaded with req_load becomes the target at the first frame strobe in a later cycle. A load in the same cycle as a strobe is not seen by that strobe.
- R5: Mute is active when mute_pin or mute_ctl is high at the strobe. While mute is active, the target of both channels is code 0. When mute is released, the levels ramp back to the request at one code per frame.
- R6: At each strobe, the output register takes floor(sample × applied level / 2^LVL_W), using the level from before that strobe's step. Level code 0 yields exactly 0.
- R7: A channel's silence flag is set at the strobe that completes ZERO_RUN+1 consecutive zero samples (1025 by default). It is still 0 after ZERO_RUN zero samples.
- R8: A non-zero sample at a strobe clears that channel's zero count and its silence flag at that same strobe.
- R9: soft_pd high at a clock edge restores every register to its R1 value. This includes dropping a pending request.
- R10: A ramp from 0x3FF to request 0 reaches level 0 after 1023 strobes. The output of strobe 1023 is the sample × 1/1024, and from strobe 1024 on the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_pd | input | 1 | Synchronous power-down clear |
| frame_stb | input | 1 | One-cycle strobe per sample frame |
| smp_l | input | DATA_W | Left input sample, two's complement |
| smp_r | input | DATA_W | Right input sample, two's complement |
| req_load | input | 1 | Load pulse for the requested levels |
| req_lvl_l | input | LVL_W | Requested left level |
| req_lvl_r | input | LVL_W | Requested right level |
| mute_pin | input | 1 | External mute request |
| mute_ctl | input | 1 | Register mute request |
| out_l | output | DATA_W | Scaled left sample |
| out_r | output | DATA_W | Scaled right sample |
| zero_l | output | 1 | Left silence flag |
| zero_r | output | 1 | Right silence flag |

## Verification
Two events can land in the same clock: a request load and a frame strobe. The bench drives req_load and frame_stb together while a ramp has already settled. It then checks, through a sample of 1024 (whose output equals the level), that the level holds at that strobe and steps only at the next one. Mute release and ramping back toward a changed request also meet in one frame. The per-clock reference model judges both against the output sequence.

// File: rtl/avr_pkg.sv
package avr_pkg;
   typedef enum logic [1:0] {
      AVR_HOLD = 2'd0,
      AVR_UP   = 2'd1,
      AVR_DOWN = 2'd2
   } avr_step_e;

   function automatic avr_step_e avr_dir(input int unsigned cur, input int unsigned tgt);
      if (cur < tgt)      return AVR_UP;
      else if (cur > tgt) return AVR_DOWN;
      else                return AVR_HOLD;
   endfunction
endpackage

// File: rtl/avr_level_ramp.sv
module avr_level_ramp
   import avr_pkg::*;
#(
   parameter int LVL_W = 10
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_pd,
   input  logic             frame_stb,
   input  logic             mute,
   input  logic             req_load,
   input  logic [LVL_W-1:0] req_new,
   output logic [LVL_W-1:0] act
);
   localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

   logic [LVL_W-1:0] req_q, pend_q, act_q, tgt_req, tgt;
   logic             pend_v;
   avr_step_e        dir;

   always_comb begin
      tgt_req = pend_v ? pend_q : req_q;
      tgt     = mute ? '0 : tgt_req;
      dir     = avr_dir(int'(act_q), int'(tgt));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= LVL_MAX;
         pend_q <= LVL_MAX;
         pend_v <= 1'b0;
         act_q  <= LVL_MAX;
      end else if (soft_pd) begin
         req_q  <= LVL_MAX;
         pend_q <= LVL_MAX;
         pend_v <= 1'b0;
         act_q  <= LVL_MAX;
      end else begin
         if (frame_stb) begin
            req_q <= tgt_req;
            case (dir)
               AVR_UP:   act_q <= act_q + 1'b1;
               AVR_DOWN: act_q <= act_q - 1'b1;
               default:  act_q <= act_q;
            endcase
         end
         if (req_load) begin
            pend_q <= req_new;
            pend_v <= 1'b1;
         end else if (frame_stb) begin
            pend_v <= 1'b0;
         end
      end
   end

   assign act = act_q;
endmodule

// File: rtl/avr_scaler.sv
module avr_scaler #(
   parameter int DATA_W    = 24,
   parameter int LVL_W     = 10,
   parameter bit SAT_UNITY = 1'b0
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_pd,
   input  logic                     frame_stb,
   input  logic signed [DATA_W-1:0] smp,
   input  logic [LVL_W-1:0]         act,
   output logic signed [DATA_W-1:0] out
);
   localparam int PROD_W = DATA_W + LVL_W + 1;

   logic signed [PROD_W-1:0] prod;
   logic signed [DATA_W-1:0] scaled, sel;

   always_comb begin
      prod   = PROD_W'(smp) * PROD_W'($signed({1'b0, act}));
      scaled = DATA_W'(prod >>> LVL_W);
   end

   generate
      if (SAT_UNITY) begin : g_unity
         assign sel = (act == {LVL_W{1'b1}}) ? smp : scaled;
      end else begin : g_floor
         assign sel = scaled;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out <= '0;
      else if (soft_pd)   out <= '0;
      else if (frame_stb) out <= sel;
   end
endmodule

// File: rtl/avr_zero_watch.sv
module avr_zero_watch #(
   parameter int DATA_W   = 24,
   parameter int ZERO_RUN = 1024
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_pd,
   input  logic              frame_stb,
   input  logic [DATA_W-1:0] smp,
   output logic              flag
);
   localparam int CNT_W = $clog2(ZERO_RUN + 2);
   localparam logic [CNT_W-1:0] RUN_C = CNT_W'(ZERO_RUN);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (soft_pd) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (frame_stb) begin
         if (smp == '0) begin
            if (cnt <= RUN_C) cnt <= cnt + 1'b1;
            flag <= (cnt >= RUN_C);
         end else begin
            cnt  <= '0;
            flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/audio_vol_ramp.sv
module audio_vol_ramp #(
   parameter int DATA_W    = 24,
   parameter int LVL_W     = 10,
   parameter int ZERO_RUN  = 1024,
   parameter bit SAT_UNITY = 1'b0
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_pd,
   input  logic                     frame_stb,
   input  logic signed [DATA_W-1:0] smp_l,
   input  logic signed [DATA_W-1:0] smp_r,
   input  logic                     req_load,
   input  logic [LVL_W-1:0]         req_lvl_l,
   input  logic [LVL_W-1:0]         req_lvl_r,
   input  logic                     mute_pin,
   input  logic                     mute_ctl,
   output logic signed [DATA_W-1:0] out_l,
   output logic signed [DATA_W-1:0] out_r,
   output logic                     zero_l,
   output logic                     zero_r
);
   localparam int NCH = 2;

   if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl
      $error("audio_vol_ramp: LVL_W out of range");
   end
   if (DATA_W < 8 || DATA_W > 32) begin : g_bad_data
      $error("audio_vol_ramp: DATA_W out of range");
   end
   if (ZERO_RUN < 1) begin : g_bad_run
      $error("audio_vol_ramp: ZERO_RUN must be positive");
   end

   logic                     mute_any;
   logic signed [DATA_W-1:0] smp_a [NCH];
   logic [LVL_W-1:0]         req_a [NCH];
   logic [LVL_W-1:0]         act_a [NCH];
   logic signed [DATA_W-1:0] out_a [NCH];
   logic                     zf_a  [NCH];
   logic [LVL_W-1:0]         act_l, act_r;

   assign mute_any = mute_pin | mute_ctl;
   assign smp_a[0] = smp_l;
   assign smp_a[1] = smp_r;
   assign req_a[0] = req_lvl_l;
   assign req_a[1] = req_lvl_r;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      avr_level_ramp #(.LVL_W(LVL_W)) u_ramp (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_pd   (soft_pd),
         .frame_stb (frame_stb),
         .mute      (mute_any),
         .req_load  (req_load),
         .req_new   (req_a[c]),
         .act       (act_a[c])
      );
      avr_scaler #(.DATA_W(DATA_W), .LVL_W(LVL_W), .SAT_UNITY(SAT_UNITY)) u_scale (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_pd   (soft_pd),
         .frame_stb (frame_stb),
         .smp       (smp_a[c]),
         .act       (act_a[c]),
         .out       (out_a[c])
      );
      avr_zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_pd   (soft_pd),
         .frame_stb (frame_stb),
         .smp       (smp_a[c]),
         .flag      (zf_a[c])
      );
   end

   assign act_l  = act_a[0];
   assign act_r  = act_a[1];
   assign out_l  = out_a[0];
   assign out_r  = out_a[1];
   assign zero_l = zf_a[0];
   assign zero_r = zf_a[1];
endmodule

// File: rtl/avr_checker.sv
module avr_checker #(
   parameter int DATA_W = 24,
   parameter int LVL_W  = 10
)(
   input logic                     clk,
   input logic                     rst_n,
   input logic                     soft_pd,
   input logic                     frame_stb,
   input logic signed [DATA_W-1:0] smp_l,
   input logic [LVL_W-1:0]         act_l,
   input logic [LVL_W-1:0]         act_r,
   input logic signed [DATA_W-1:0] out_l,
   input logic                     zero_l
);
   localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

   a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !soft_pd) |=>
         ({1'b0, act_l} == {1'b0, $past(act_l)}) ||
         ({1'b0, act_l} == {1'b0, $past(act_l)} + 1'b1) ||
         ({1'b0, $past(act_l)} == {1'b0, act_l} + 1'b1));

   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && !soft_pd) |=> ($stable(act_l) && $stable(act_r) && $stable(out_l)));

   a_r6_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !soft_pd && act_l == '0) |=> (out_l == '0));

   a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !soft_pd && smp_l != '0) |=> !zero_l);

   a_r9_power_down: assert property (@(posedge clk) disable iff (!rst_n)
      soft_pd |=> (act_l == LVL_MAX && act_r == LVL_MAX && out_l == '0 && !zero_l));
endmodule

bind audio_vol_ramp avr_checker #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_avr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_pd   (soft_pd),
   .frame_stb (frame_stb),
   .smp_l     (smp_l),
   .act_l     (act_l),
   .act_r     (act_r),
   .out_l     (out_l),
   .zero_l    (zero_l)
);

// File: tb/test_audio_vol_ramp.sv
`timescale 1ns/1ps
module test_audio_vol_ramp;
   localparam int DW = 24;
   localparam int LW = 10;
   localparam int ZR = 1024;
   localparam int LMAX = (1 << LW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_pd = 1'b0, frame_stb = 1'b0, req_load = 1'b0;
   logic mute_pin = 1'b0, mute_ctl = 1'b0;
   logic signed [DW-1:0] smp_l = '0, smp_r = '0;
   logic [LW-1:0] req_lvl_l = '0, req_lvl_r = '0;
   logic signed [DW-1:0] out_l, out_r;
   logic zero_l, zero_r;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   audio_vol_ramp #(.DATA_W(DW), .LVL_W(LW), .ZERO_RUN(ZR)) i_audio_vol_ramp (
      .clk(clk), .rst_n(rst_n), .soft_pd(soft_pd), .frame_stb(frame_stb),
      .smp_l(smp_l), .smp_r(smp_r), .req_load(req_load),
      .req_lvl_l(req_lvl_l), .req_lvl_r(req_lvl_r),
      .mute_pin(mute_pin), .mute_ctl(mute_ctl),
      .out_l(out_l), .out_r(out_r), .zero_l(zero_l), .zero_r(zero_r));

   // behavioural reference model
   longint m_act[2], m_req[2], m_pend[2], m_out[2], m_cnt[2];
   bit     m_flag[2], m_pv;

   task automatic m_clear();
      for (int c = 0; c < 2; c++) begin
         m_act[c] = LMAX; m_req[c] = LMAX; m_pend[c] = LMAX;
         m_out[c] = 0; m_cnt[c] = 0; m_flag[c] = 1'b0;
      end
      m_pv = 1'b0;
   endtask

   always @(posedge clk) begin
      if (!rst_n || soft_pd) m_clear();
      else begin
         if (frame_stb) begin
            for (int c = 0; c < 2; c++) begin
               longint s, tr, tg;
               s  = (c == 0) ? longint'(smp_l) : longint'(smp_r);
               tr = m_pv ? m_pend[c] : m_req[c];
               tg = (mute_pin || mute_ctl) ? 0 : tr;
               m_out[c] = (s * m_act[c]) >>> LW;
               if (m_act[c] < tg) m_act[c]++;
               else if (m_act[c] > tg) m_act[c]--;
               m_req[c] = tr;
               if (s == 0) begin
                  m_cnt[c]++;
                  m_flag[c] = (m_cnt[c] > ZR);
               end else begin
                  m_cnt[c] = 0; m_flag[c] = 1'b0;
               end
            end
            m_pv = 1'b0;
         end
         if (req_load) begin
            m_pend[0] = req_lvl_l; m_pend[1] = req_lvl_r; m_pv = 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R6 model out_l", longint'(out_l), m_out[0]);
         chk("R6 model out_r", longint'(out_r), m_out[1]);
         chk("R7 model zero_l", longint'(zero_l), longint'(m_flag[0]));
         chk("R7 model zero_r", longint'(zero_r), longint'(m_flag[1]));
      end
   end

   task automatic frame(input longint sl, input longint sr);
      @(negedge clk);
      frame_stb = 1'b1; smp_l = DW'(sl); smp_r = DW'(sr);
      @(negedge clk);
      frame_stb = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic load(input int l, input int r);
      @(negedge clk);
      req_load = 1'b1; req_lvl_l = LW'(l); req_lvl_r = LW'(r);
      @(negedge clk);
      req_load = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset out_l", longint'(out_l), 0);
      chk("R1 reset zero_r", longint'(zero_r), 0);

      frame(1024, -1024);
      chk("R1 R6 unity level out_l", longint'(out_l), 1023);
      chk("R6 negative out_r", longint'(out_r), -1023);
      frame(-1, 1);
      chk("R6 floor negative", longint'(out_l), -1);
      chk("R6 floor positive", longint'(out_r), 0);

      load(12'h3F0, 12'h3FF);
      frame(1024, 1024);
      chk("R2 first step uses old level", longint'(out_l), 1023);
      frame(1024, 1024);
      chk("R2 one code per frame", longint'(out_l), 1022);
      repeat (13) frame(1024, 1024);
      frame(1024, 1024);
      chk("R2 reached target", longint'(out_l), 1008);
      frame(1024, 1024);
      chk("R2 holds at target", longint'(out_l), 1008);
      @(negedge clk);
      chk("R3 stable between frames", longint'(out_l), 1008);

      // load coincides with a frame strobe
      @(negedge clk);
      frame_stb = 1'b1; req_load = 1'b1; req_lvl_l = LW'(12'h3FF); req_lvl_r = LW'(12'h3FF);
      @(negedge clk);
      frame_stb = 1'b0; req_load = 1'b0;
      repeat (2) @(negedge clk);
      chk("R4 coincident strobe out", longint'(out_l), 1008);
      frame(1024, 1024);
      chk("R4 coincident load not yet applied", longint'(out_l), 1008);
      frame(1024, 1024);
      chk("R4 applied at next strobe", longint'(out_l), 1009);

      mute_pin = 1'b1;
      frame(1024, 1024);
      frame(1024, 1024);
      chk("R5 pin mute ramps down", longint'(out_l), 1009);
      mute_pin = 1'b0; mute_ctl = 1'b1;
      frame(1024, 1024);
      chk("R5 register mute ramps down", longint'(out_r), 1021);
      mute_ctl = 1'b0;
      frame(1024, 1024);
      frame(1024, 1024);
      chk("R5 release ramps up left", longint'(out_l), 1008);
      chk("R5 release ramps up right", longint'(out_r), 1021);

      // pending request dropped by power-down
      load(5, 5);
      @(negedge clk); soft_pd = 1'b1;
      @(negedge clk); soft_pd = 1'b0;
      chk("R9 output cleared", longint'(out_l), 0);
      frame(1024, 1024);
      chk("R9 level restored", longint'(out_l), 1023);
      frame(1024, 1024);
      chk("R9 pending request dropped", longint'(out_r), 1023);

      load(0, 12'h3FF);
      for (int k = 0; k < 1023; k++) frame(1024, 1024);
      chk("R10 last non-zero step", longint'(out_l), 1);
      frame(1024, 1024);
      chk("R10 full swing reaches zero", longint'(out_l), 0);
      frame((1 << (DW-1)) - 1, 1024);
      chk("R6 code zero gives zero", longint'(out_l), 0);
      chk("R2 unchanged channel", longint'(out_r), 1023);

      for (int k = 0; k < ZR; k++) frame(3, 0);
      chk("R7 not set at run length", longint'(zero_r), 0);
      frame(3, 0);
      chk("R7 set past run length", longint'(zero_r), 1);
      chk("R7 other channel clear", longint'(zero_l), 0);
      frame(5, 7);
      chk("R8 non-zero clears flag", longint'(zero_r), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule